// File: doc/BRIEF.md
# Host-Cleared Interrupt Latch with AXI4-Lite Register Access

This block sits between user logic and the user-interrupt port of a PCIe DMA engine. Each of four request lines from user logic is watched for a rising edge; an edge sets a sticky pending bit for that line. The pending bits, gated by a per-line enable mask, drive the interrupt request lines toward the DMA engine. They stay asserted until host software clears them, even after the engine has acknowledged the request.

A host driver reaches the block through an AXI4-Lite slave. Through it, the driver reads which lines are pending and which the engine has acknowledged. It clears serviced lines by writing ones to a write-one-to-clear register and adjusts the enable mask. Word offsets are: 0x00 pending (read-only), 0x04 clear (write-one-to-clear, reads zero), 0x08 enable mask (read/write), 0x0C acknowledged (read-only). Data sits in bits [3:0], bit i for line i, and upper bits read zero. The AXI side is the only flow-controlled interface. A write is taken only when address and data are both valid and no write response is waiting. The response is held until the master takes it with `s_bready`. A read is taken only when no read data is waiting, and the data is held until `s_rready`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending and acknowledged registers read 0, `irq_req` is 0, and the enable mask at 0x08 reads 0xF.
- R2: A rising edge on `req_in[i]` sets pending bit i one clock edge later. An input held high does not set the bit again after it is cleared.
- R3: `irq_req[i]` is high exactly when pending bit i and enable bit i are both 1. It stays high through an acknowledge on `irq_ack[i]` until the bit is cleared.
- R4: Writing 0x04 with bit i = 1 clears pending bit i and acknowledged bit i at the write handshake edge. Bits written 0 leave their lines unchanged.
- R5: When a rising request edge and a clear of the same line fall on the same clock edge, the line stays pending.
- R6: The enable mask at 0x08 is read/write in bits [3:0]. Masking a line hides its `irq_req` but keeps its pending bit. Unmasking a pending line raises `irq_req` again.
- R7: A pulse on `irq_ack[i]` while line i is pending sets bit i of the register at 0x0C. An acknowledge on a line that is not pending is ignored.
- R8: A read of 0x00 returns the pending bits in [3:0] and zeros above.
- R9: Reads of 0x04 and of unmapped offsets (0x10 and up) return zero. Writes to 0x00 and 0x0C change nothing. Every response is OKAY (2'b00).
- R10: `s_awready`/`s_wready` are high only when both `s_awvalid` and `s_wvalid` are high and no write response is waiting. `s_bvalid` and `s_bresp` hold until `s_bready`. `s_arready` is low while read data is waiting. `s_rvalid` and `s_rdata` hold until `s_rready`.
- R11: A write whose byte strobe `s_wstrb[0]` is 0 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 4 | Request lines from user logic, rising edge = request |
| irq_req | output | 4 | Interrupt requests toward the DMA engine |
| irq_ack | input | 4 | Per-line acknowledge pulses from the DMA engine |
| s_awaddr | input | 5 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 5 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
A request edge shows on `irq_req` and in the pending register one clock edge after it is sampled. A clear, enable or ignored write takes effect at the very edge where the write handshake happens. The write response and the read data each appear one edge after their handshake. The bench drives every input and samples every output on the falling clock edge. Each check is therefore placed on the first falling edge after the rising edge that should produce the result. The same-edge race between a request and a clear is set up by driving both on one falling edge, so that the next rising edge sees them together.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // Word indices (byte offset >> 2) of the register map
  localparam int unsigned WORD_PENDING = 0;
  localparam int unsigned WORD_CLEAR   = 1;
  localparam int unsigned WORD_ENABLE  = 2;
  localparam int unsigned WORD_ACKED   = 3;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axil_resp_e;
endpackage

// File: rtl/irq_axil_slave.sv
module irq_axil_slave
  import irq_latch_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  localparam int WORD_W   = ADDR_W - 2,
  localparam int STRB_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_fire,
  output logic [WORD_W-1:0] wr_word,
  output logic [NUM_LINES-1:0] wr_bits,
  output logic              wr_lane0,
  output logic [WORD_W-1:0] rd_word,
  input  logic [DATA_W-1:0] rd_value
);
  logic bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic aw_go, ar_go;
  logic unused_bits;

  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[DATA_W-1:NUM_LINES], s_wstrb[STRB_W-1:1]};

  // Write channel: address and data are taken together, one response at a time
  assign aw_go     = s_awvalid && s_wvalid && !bvalid_q;
  assign s_awready = aw_go;
  assign s_wready  = aw_go;
  assign wr_fire   = aw_go;
  assign wr_word   = s_awaddr[ADDR_W-1:2];
  assign wr_bits   = s_wdata[NUM_LINES-1:0];
  assign wr_lane0  = s_wstrb[0];

  always_ff @(posedge clk) begin
    if (!rst_n)        bvalid_q <= 1'b0;
    else if (aw_go)    bvalid_q <= 1'b1;
    else if (s_bready) bvalid_q <= 1'b0;
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = RESP_OKAY;

  // Read channel: one outstanding read, data captured at the address handshake
  assign ar_go     = s_arvalid && !rvalid_q;
  assign s_arready = !rvalid_q;
  assign rd_word   = s_araddr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ar_go) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_value;
    end else if (s_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = RESP_OKAY;

  // R10
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  // R10
  aw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready && !s_wready);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R10
  ar_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic ack_in,
  input  logic clr_in,
  input  logic en_in,
  output logic pending_o,
  output logic acked_o,
  output logic irq_o
);
  logic req_d, pend_q, ack_q;
  logic rise;

  assign rise = req_in && !req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d  <= 1'b0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      req_d <= req_in;
      // a new request edge wins over a clear on the same edge
      if (rise)        pend_q <= 1'b1;
      else if (clr_in) pend_q <= 1'b0;
      if (clr_in)                ack_q <= 1'b0;
      else if (ack_in && pend_q) ack_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign acked_o   = ack_q;
  assign irq_o     = pend_q && en_in;

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pending_o);
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o && !clr_in |=> pending_o);
  // R4
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in && !(req_in && !req_d) |=> !pending_o && !acked_o);
  // R7
  ack_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acked_o |-> pending_o);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_latch_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [WORD_W-1:0]    wr_word,
  input  logic [NUM_LINES-1:0] wr_bits,
  input  logic                 wr_lane0,
  input  logic [WORD_W-1:0]    rd_word,
  input  logic [NUM_LINES-1:0] pending,
  input  logic [NUM_LINES-1:0] acked,
  output logic [DATA_W-1:0]    rd_value,
  output logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] enable
);
  logic wr_ok;
  logic [NUM_LINES-1:0] en_q;

  assign wr_ok    = wr_fire && wr_lane0;
  assign clr_mask = (wr_ok && wr_word == WORD_W'(WORD_CLEAR)) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '1;
    else if (wr_ok && wr_word == WORD_W'(WORD_ENABLE))
      en_q <= wr_bits;
  end

  assign enable = en_q;

  always_comb begin
    rd_value = '0;
    if (rd_word == WORD_W'(WORD_PENDING))     rd_value[NUM_LINES-1:0] = pending;
    else if (rd_word == WORD_W'(WORD_ENABLE)) rd_value[NUM_LINES-1:0] = en_q;
    else if (rd_word == WORD_W'(WORD_ACKED))  rd_value[NUM_LINES-1:0] = acked;
  end

  // R11
  strb_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !wr_lane0 |=> $stable(enable));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  localparam int WORD_W   = ADDR_W - 2,
  localparam int STRB_W   = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  output logic [NUM_LINES-1:0] irq_req,
  input  logic [NUM_LINES-1:0] irq_ack,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [DATA_W-1:0]    s_wdata,
  input  logic [STRB_W-1:0]    s_wstrb,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  output logic [1:0]           s_bresp,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  input  logic [ADDR_W-1:0]    s_araddr,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  output logic [DATA_W-1:0]    s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 s_rvalid,
  input  logic                 s_rready
);
  logic                 wr_fire, wr_lane0;
  logic [WORD_W-1:0]    wr_word, rd_word;
  logic [NUM_LINES-1:0] wr_bits, pending, acked, clr_mask, enable;
  logic [DATA_W-1:0]    rd_value;

  irq_axil_slave #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_fire(wr_fire), .wr_word(wr_word), .wr_bits(wr_bits), .wr_lane0(wr_lane0),
    .rd_word(rd_word), .rd_value(rd_value)
  );

  irq_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_word(wr_word), .wr_bits(wr_bits), .wr_lane0(wr_lane0),
    .rd_word(rd_word), .pending(pending), .acked(acked),
    .rd_value(rd_value), .clr_mask(clr_mask), .enable(enable)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line u_line (
      .clk(clk), .rst_n(rst_n),
      .req_in(req_in[i]), .ack_in(irq_ack[i]), .clr_in(clr_mask[i]), .en_in(enable[i]),
      .pending_o(pending[i]), .acked_o(acked[i]), .irq_o(irq_req[i])
    );
  end

  // R6
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~enable) == '0);
  // R3
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~pending) == '0);
endmodule

// File: tb/irq_latch_ctrl_bench.sv
`timescale 1ns/1ps
module irq_latch_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] req_in = '0, irq_ack = '0, irq_req;
  logic [4:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic [3:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl u_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .irq_req(irq_req), .irq_ack(irq_ack),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Write with immediate response acceptance; checks OKAY response (R9)
  task automatic axi_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1; s_wvalid = 1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    chk("R9 bresp", {30'd0, s_bresp}, 32'h0);
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic axi_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 0;
    d = s_rdata;
    chk("R9 rresp", {30'd0, s_rresp}, 32'h0);
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
  endtask

  task automatic pulse_req(input logic [3:0] m);
    @(negedge clk); req_in = m;
    @(negedge clk); req_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_req", {28'd0, irq_req}, 0);
    axi_rd(5'h00, d); chk("R1 pending", d, 0);
    axi_rd(5'h08, d); chk("R1 enable", d, 32'hF);
    axi_rd(5'h0C, d); chk("R1 acked", d, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    @(negedge clk); req_in = 4'b0010;
    @(negedge clk); chk("R2 set one edge later", {28'd0, irq_req}, 4'b0010);
    req_in = '0;
    axi_rd(5'h00, d); chk("R8 pending read", d, 32'h2);
    // level held high: no re-set after clear
    @(negedge clk); req_in = 4'b0100;
    @(negedge clk); chk("R3 irq two lines", {28'd0, irq_req}, 4'b0110);
    axi_wr(5'h04, 32'h4, 4'hF);
    repeat (2) @(negedge clk);
    chk("R2 held level no re-set", {28'd0, irq_req}, 4'b0010);
    req_in = '0;
  endtask

  task automatic t_ack;
    logic [31:0] d;
    @(negedge clk); irq_ack = 4'b0010;
    @(negedge clk); irq_ack = 4'b1000;
    @(negedge clk); irq_ack = '0;
    chk("R3 held after ack", {28'd0, irq_req}, 4'b0010);
    axi_rd(5'h0C, d); chk("R7 acked only pending line", d, 32'h2);
    axi_wr(5'h04, 32'h2, 4'hF);
    chk("R4 irq cleared", {28'd0, irq_req}, 0);
    axi_rd(5'h00, d); chk("R4 pending cleared", d, 0);
    axi_rd(5'h0C, d); chk("R4 acked cleared", d, 0);
    pulse_req(4'b1001);
    axi_wr(5'h04, 32'h1, 4'hF);
    axi_rd(5'h00, d); chk("R4 zero bits untouched", d, 32'h8);
    axi_wr(5'h04, 32'h8, 4'hF);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse_req(4'b0001);
    @(negedge clk);
    s_awaddr = 5'h04; s_wdata = 32'h1; s_wstrb = 4'hF; s_awvalid = 1; s_wvalid = 1;
    req_in = 4'b0001;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; req_in = '0; s_bready = 1;
    chk("R5 request wins over clear", {28'd0, irq_req}, 4'b0001);
    @(negedge clk); s_bready = 0;
    axi_rd(5'h00, d); chk("R5 still pending", d, 32'h1);
    axi_wr(5'h04, 32'h1, 4'hF);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    axi_wr(5'h08, 32'h5, 4'hF);
    axi_rd(5'h08, d); chk("R6 enable readback", d, 32'h5);
    pulse_req(4'b1111);
    chk("R6 masked irq", {28'd0, irq_req}, 4'b0101);
    axi_rd(5'h00, d); chk("R6 pending kept", d, 32'hF);
    axi_wr(5'h08, 32'hF, 4'hF);
    chk("R6 unmask raises irq", {28'd0, irq_req}, 4'b1111);
    axi_wr(5'h04, 32'hF, 4'hF);
  endtask

  task automatic t_map;
    logic [31:0] d;
    pulse_req(4'b0001);
    @(negedge clk); irq_ack = 4'b0001;
    @(negedge clk); irq_ack = '0;
    axi_wr(5'h00, 32'h0, 4'hF);
    axi_rd(5'h00, d); chk("R9 write to pending ignored", d, 32'h1);
    axi_wr(5'h0C, 32'h0, 4'hF);
    axi_rd(5'h0C, d); chk("R9 write to acked ignored", d, 32'h1);
    axi_rd(5'h10, d); chk("R9 unmapped reads zero", d, 0);
    axi_rd(5'h1C, d); chk("R9 unmapped high reads zero", d, 0);
    axi_rd(5'h04, d); chk("R9 clear reads zero", d, 0);
    axi_wr(5'h04, 32'h1, 4'hF);
  endtask

  task automatic t_strb;
    logic [31:0] d;
    axi_wr(5'h08, 32'h0, 4'b1110);
    axi_rd(5'h08, d); chk("R11 strobe-off enable write ignored", d, 32'hF);
    pulse_req(4'b0010);
    axi_wr(5'h04, 32'h2, 4'b0000);
    chk("R11 strobe-off clear ignored", {28'd0, irq_req}, 4'b0010);
    axi_wr(5'h04, 32'h2, 4'hF);
  endtask

  task automatic t_hs;
    logic [31:0] d;
    @(negedge clk);
    s_awaddr = 5'h08; s_wdata = 32'hF; s_wstrb = 4'hF; s_awvalid = 1; s_wvalid = 0;
    #1; chk("R10 awready needs wvalid", {31'd0, s_awready}, 0);
    s_wvalid = 1;
    #1; chk("R10 awready with both valid", {31'd0, s_awready}, 1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 bvalid held", {31'd0, s_bvalid}, 1);
      chk("R10 second write blocked", {31'd0, s_awready}, 0);
      @(negedge clk);
    end
    s_bready = 1;
    @(negedge clk);
    #1; chk("R10 next write accepted", {31'd0, s_awready}, 1);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    @(negedge clk); s_bready = 0;
    // read held while rready low
    pulse_req(4'b0100);
    @(negedge clk); s_araddr = 5'h00; s_arvalid = 1;
    @(negedge clk); s_arvalid = 0;
    pulse_req(4'b0001);
    for (int k = 0; k < 3; k++) begin
      chk("R10 rvalid held", {31'd0, s_rvalid}, 1);
      chk("R10 rdata stable", s_rdata, 32'h4);
      chk("R10 arready low", {31'd0, s_arready}, 0);
      @(negedge clk);
    end
    s_rready = 1;
    @(negedge clk); chk("R10 rvalid dropped", {31'd0, s_rvalid}, 0);
    s_rready = 0;
    axi_rd(5'h00, d); chk("R8 pending after hold", d, 32'h5);
    axi_wr(5'h04, 32'hF, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_ack();
    t_race();
    t_mask();
    t_map();
    t_strb();
    t_hs();
    repeat (2) @(negedge clk);
    report();
  end
endmodule